// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer Channel

This block is a single 16-bit timer channel that counts down on a tick enable and drives one output pin whose waveform depends on a 3-bit mode. A load strobe presents an initial count and a mode together. The channel then runs in one of six behaviours: a terminal-count flag, a one-shot window, a periodic rate pulse, a square wave, and two single-tick strobes. Between them the behaviours differ in how the gate input affects counting and in how the readable count moves.

The count output is always valid. It follows the loaded count minus the ticks elapsed since the last start. In the periodic modes it wraps within the period, and in square-wave mode it falls two steps per tick. A gate input can pause counting. In some modes a rising edge on the gate restarts the count from the loaded value instead. The integrating logic supplies the tick enable from its own prescaler and connects the gate and output wherever the channel is needed.

Top module: `tick_timer_channel`

## Requirements
- R1: After reset the loaded span is 65536, the mode is 0, the readable count is 0 and the output is low.
- R2: In modes 0, 1, 4 and 5 the readable count is (span − elapsed ticks) modulo 65536, where elapsed ticks are those counted since the last load or restart.
- R3: In mode 2 the readable count is span − (elapsed modulo span), truncated to 16 bits, so it reloads every period.
- R4: In mode 3 the readable count is span − ((2 × elapsed) modulo span), truncated to 16 bits.
- R5: In mode 0 the output is high once elapsed ≥ span and stays high until the next load.
- R6: In mode 1 the output is high while elapsed < span and low afterwards.
- R7: In mode 2 the output is high exactly when elapsed is a nonzero multiple of span.
- R8: In mode 3 the output is high while (elapsed modulo span) < (span+1)/2, giving the longer phase high for odd spans.
- R9: In modes 4 and 5 the output is high only while elapsed equals span.
- R10: A loaded count of 0 sets a span of 65536.
- R11: Mode codes 6 and 7 behave as modes 2 and 3.
- R12: With the gate low, ticks are not counted in modes 0, 2, 3 and 4, and the count and output hold. In modes 1 and 5 the gate level does not affect counting.
- R13: A gate rising edge (gate high now, low at the previous clock) sets elapsed to 0 in modes 1, 2, 3 and 5 and has no effect in modes 0 and 4.
- R14: A load takes priority over a retrigger and a tick in the same clock, and takes effect on the next clock with elapsed 0. Without tick enable, and without a load or retrigger, the state holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count one tick this clock |
| gateIn | input | 1 | Gate level; pauses or retriggers depending on mode |
| loadStb | input | 1 | Load loadCount and loadMode this clock |
| loadCount | input | 16 | Initial count; 0 means 65536 |
| loadMode | input | 3 | Counting mode 0 to 7 |
| outPin | output | 1 | Channel output level |
| countVal | output | 16 | Current readable count |

## Verification
The corners hardest to reach from the ports are the full 65536-tick span and the square wave's double-rate wrap with odd and even spans. The stimulus reaches the full span by loading a count of 0 in mode 0 and ticking past the terminal count. It covers the wrap by running mode 3 with spans of 3, 7 and 8, with both steady and sparse tick patterns. Retriggers are placed against gate-low pauses and against loads in the same clock, so that the priority between load, retrigger and tick shows up in the count.

// File: rtl/ttc_pkg.sv
package ttc_pkg;

  typedef enum logic [2:0] {
    MODE_TERM     = 3'd0,
    MODE_ONESHOT  = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } chanMode_e;

  typedef struct packed {
    logic load;
    logic restart;
    logic step;
  } chanStb_t;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic chanMode_e foldMode(input logic [2:0] m);
    if (m[2] && m[1]) return chanMode_e'({1'b0, m[1:0]});
    return chanMode_e'(m);
  endfunction

endpackage

// File: rtl/ttc_ctrl.sv
module ttc_ctrl
  import ttc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      gateIn,
  input  logic      loadStb,
  input  logic [2:0] loadMode,
  output chanStb_t  stb,
  output chanMode_e modeEff
);

  logic [2:0] modeQ;
  logic       gatePrev;
  logic       gateRise;
  logic       pauseOnLow;
  logic       retrigMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= 3'd0;
      gatePrev <= 1'b0;
    end else begin
      gatePrev <= gateIn;
      if (loadStb) modeQ <= loadMode;
    end
  end

  assign modeEff  = foldMode(modeQ);
  assign gateRise = gateIn && !gatePrev;

  always_comb begin
    unique case (modeEff)
      MODE_TERM, MODE_SWSTROBE: begin pauseOnLow = 1'b1; retrigMode = 1'b0; end
      MODE_RATE, MODE_SQUARE:   begin pauseOnLow = 1'b1; retrigMode = 1'b1; end
      default:                  begin pauseOnLow = 1'b0; retrigMode = 1'b1; end
    endcase
  end

  always_comb begin
    stb.load    = loadStb;
    stb.restart = !loadStb && gateRise && retrigMode;
    stb.step    = !loadStb && !stb.restart && tickEn && (gateIn || !pauseOnLow);
  end

endmodule

// File: rtl/ttc_datapath.sv
module ttc_datapath
  import ttc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanStb_t         stb,
  input  logic [CNT_W-1:0] loadCount,
  output logic [CNT_W:0]   spanQ,
  output logic [CNT_W-1:0] downQ,
  output logic [CNT_W:0]   phaseQ,
  output logic             passedQ,
  output logic             exactQ,
  output logic             startedQ
);

  localparam logic [CNT_W:0]   SPAN_MAX = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W-1:0] ONE_CNT  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W:0] spanNext;
  logic [CNT_W:0] phaseInc;
  logic           lastTick;

  assign spanNext = (loadCount == '0) ? SPAN_MAX : {1'b0, loadCount};
  assign phaseInc = phaseQ + 1'b1;
  assign lastTick = (downQ == ONE_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spanQ    <= SPAN_MAX;
      downQ    <= '0;
      phaseQ   <= '0;
      passedQ  <= 1'b0;
      exactQ   <= 1'b0;
      startedQ <= 1'b0;
    end else if (stb.load || stb.restart) begin
      if (stb.load) begin
        spanQ <= spanNext;
        downQ <= loadCount;
      end else begin
        downQ <= spanQ[CNT_W-1:0];
      end
      phaseQ   <= '0;
      passedQ  <= 1'b0;
      exactQ   <= 1'b0;
      startedQ <= 1'b0;
    end else if (stb.step) begin
      downQ    <= downQ - 1'b1;
      phaseQ   <= (phaseInc == spanQ) ? '0 : phaseInc;
      passedQ  <= passedQ || lastTick;
      exactQ   <= !passedQ && lastTick;
      startedQ <= 1'b1;
    end
  end

endmodule

// File: rtl/ttc_view.sv
module ttc_view
  import ttc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  chanMode_e        modeEff,
  input  logic [CNT_W:0]   spanQ,
  input  logic [CNT_W-1:0] downQ,
  input  logic [CNT_W:0]   phaseQ,
  input  logic             passedQ,
  input  logic             exactQ,
  input  logic             startedQ,
  output logic             outPin,
  output logic [CNT_W-1:0] countVal
);

  localparam int WW = CNT_W + 2;

  logic [WW-1:0]    twoPhase;
  logic [WW-1:0]    spanWide;
  logic [WW-1:0]    halfSpan;
  logic             twoWraps;
  logic [CNT_W-1:0] wrapLow;
  logic [CNT_W-1:0] rateCnt;
  logic [CNT_W-1:0] squareCnt;
  logic             squareHigh;

  assign twoPhase   = {phaseQ, 1'b0};
  assign spanWide   = {1'b0, spanQ};
  assign halfSpan   = (spanWide + 1'b1) >> 1;
  assign twoWraps   = (twoPhase >= spanWide);
  assign wrapLow    = twoWraps ? (twoPhase[CNT_W-1:0] - spanQ[CNT_W-1:0])
                               : twoPhase[CNT_W-1:0];
  assign rateCnt    = spanQ[CNT_W-1:0] - phaseQ[CNT_W-1:0];
  assign squareCnt  = spanQ[CNT_W-1:0] - wrapLow;
  assign squareHigh = ({1'b0, phaseQ} < halfSpan);

  always_comb begin
    unique case (modeEff)
      MODE_TERM:    begin outPin = passedQ;                    countVal = downQ;     end
      MODE_ONESHOT: begin outPin = !passedQ;                   countVal = downQ;     end
      MODE_RATE:    begin outPin = (phaseQ == '0) && startedQ; countVal = rateCnt;   end
      MODE_SQUARE:  begin outPin = squareHigh;                 countVal = squareCnt; end
      default:      begin outPin = exactQ;                     countVal = downQ;     end
    endcase
  end

endmodule

// File: rtl/tick_timer_channel.sv
module tick_timer_channel
  import ttc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             gateIn,
  input  logic             loadStb,
  input  logic [CNT_W-1:0] loadCount,
  input  logic [2:0]       loadMode,
  output logic             outPin,
  output logic [CNT_W-1:0] countVal
);

  chanStb_t         stb;
  chanMode_e        modeEff;
  logic [2:0]       modeEffBits;
  logic [CNT_W:0]   spanQ;
  logic [CNT_W-1:0] downQ;
  logic [CNT_W:0]   phaseQ;
  logic             passedQ;
  logic             exactQ;
  logic             startedQ;

  assign modeEffBits = modeEff;

  ttc_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .gateIn   (gateIn),
    .loadStb  (loadStb),
    .loadMode (loadMode),
    .stb      (stb),
    .modeEff  (modeEff)
  );

  ttc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .loadCount (loadCount),
    .spanQ     (spanQ),
    .downQ     (downQ),
    .phaseQ    (phaseQ),
    .passedQ   (passedQ),
    .exactQ    (exactQ),
    .startedQ  (startedQ)
  );

  ttc_view #(.CNT_W(CNT_W)) view_i (
    .modeEff  (modeEff),
    .spanQ    (spanQ),
    .downQ    (downQ),
    .phaseQ   (phaseQ),
    .passedQ  (passedQ),
    .exactQ   (exactQ),
    .startedQ (startedQ),
    .outPin   (outPin),
    .countVal (countVal)
  );

endmodule

// File: rtl/ttc_checker.sv
module ttc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             gateIn,
  input logic             loadStb,
  input logic             outPin,
  input logic [CNT_W-1:0] countVal,
  input logic [2:0]       modeEff
);

  // R14: no load, no tick and gate low (so no rising edge) leaves everything held
  a_r14_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !loadStb && !gateIn) |=> ($stable(countVal) && $stable(outPin)));

  // R5: terminal flag in mode 0 stays set until a load
  a_r5_term_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (modeEff == 3'd0 && outPin && !loadStb) |=> outPin);

  // R9: strobe modes drop the output after one counted tick
  a_r9_strobe_one_tick: assert property (@(posedge clk) disable iff (!rstN)
    ((modeEff == 3'd4 || modeEff == 3'd5) && outPin && tickEn && gateIn && !loadStb)
      |=> !outPin);

  // R7: rate pulse lasts one counted tick when the span exceeds one
  a_r7_rate_pulse_short: assert property (@(posedge clk) disable iff (!rstN)
    (modeEff == 3'd2 && outPin && countVal != 16'd1 && tickEn && gateIn && !loadStb)
      |=> !outPin);

  // R12: gate low pauses the non-retriggering gated modes
  a_r12_gate_pause: assert property (@(posedge clk) disable iff (!rstN)
    ((modeEff == 3'd0 || modeEff == 3'd4) && !gateIn && !loadStb)
      |=> $stable(countVal));

endmodule

bind tick_timer_channel ttc_checker #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .gateIn   (gateIn),
  .loadStb  (loadStb),
  .outPin   (outPin),
  .countVal (countVal),
  .modeEff  (modeEffBits)
);

// File: tb/tick_timer_channel_tb.sv
`timescale 1ns/1ps
module tick_timer_channel_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        gateIn = 1'b1;
  logic        loadStb = 1'b0;
  logic [15:0] loadCount = 16'd0;
  logic [2:0]  loadMode = 3'd0;
  logic        outPin;
  logic [15:0] countVal;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  longint spanM = 65536;
  longint elapM = 0;
  int     modeM = 0;
  bit     gPrevM = 0;

  always #10 clk = ~clk;

  tick_timer_channel dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .gateIn(gateIn),
    .loadStb(loadStb), .loadCount(loadCount), .loadMode(loadMode),
    .outPin(outPin), .countVal(countVal)
  );

  function automatic int fold(int m);
    return (m >= 6) ? m - 4 : m;
  endfunction

  task automatic modelEdge();
    int em;
    bit rise;
    em = fold(modeM);
    rise = gateIn && !gPrevM;
    if (!rstN) begin
      spanM = 65536; elapM = 0; modeM = 0; gPrevM = 0;
      return;
    end
    if (loadStb) begin
      modeM = loadMode;
      spanM = (loadCount == 0) ? 65536 : loadCount;
      elapM = 0;
    end else if (rise && (em == 1 || em == 2 || em == 3 || em == 5)) begin
      elapM = 0;
    end else if (tickEn && (gateIn || em == 1 || em == 5)) begin
      elapM++;
    end
    gPrevM = gateIn;
  endtask

  task automatic compare();
    int em;
    longint expC;
    bit expO;
    string rc, ro;
    em = fold(modeM);
    case (em)
      2: begin expC = (spanM - elapM % spanM) & 16'hFFFF;
               expO = (elapM % spanM == 0) && (elapM != 0); rc = "R3"; ro = "R7"; end
      3: begin expC = (spanM - (2 * elapM) % spanM) & 16'hFFFF;
               expO = (elapM % spanM) < ((spanM + 1) / 2); rc = "R4"; ro = "R8"; end
      0: begin expC = (spanM - elapM) & 16'hFFFF; expO = elapM >= spanM; rc = "R2"; ro = "R5"; end
      1: begin expC = (spanM - elapM) & 16'hFFFF; expO = elapM < spanM;  rc = "R2"; ro = "R6"; end
      default: begin expC = (spanM - elapM) & 16'hFFFF; expO = elapM == spanM; rc = "R2"; ro = "R9"; end
    endcase
    checks++;
    if (countVal !== expC[15:0]) begin
      failures++;
      $display("FAIL %s [%s] count actual=%0d expected=%0d", rc, tag, countVal, expC);
    end
    checks++;
    if (outPin !== expO) begin
      failures++;
      $display("FAIL %s [%s] out actual=%0b expected=%0b", ro, tag, outPin, expO);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare();
  endtask

  // pat: 0 every clock, 1 every other clock, 2 never
  task automatic run(int n, int pat);
    for (int i = 0; i < n; i++) begin
      tickEn = (pat == 0) || (pat == 1 && (i % 2 == 0));
      cyc();
    end
    tickEn = 1'b0;
  endtask

  task automatic load(int cnt, int mode);
    loadStb = 1'b1; loadCount = cnt[15:0]; loadMode = mode[2:0];
    cyc();
    loadStb = 1'b0;
  endtask

  initial begin
    // R1: reset values
    tag = "R1";
    run(3, 2);
    rstN = 1'b1;
    run(3, 2);

    tag = "R5 mode0";
    load(10, 0); run(15, 0);
    tag = "R12 mode0 gate low"; gateIn = 0; run(4, 0);
    tag = "R13 mode0 rise ignored"; gateIn = 1; run(3, 0);
    load(6, 0); run(3, 0); gateIn = 0; run(2, 0); gateIn = 1; run(6, 0);

    tag = "R6 mode1"; gateIn = 0;
    load(7, 1); run(4, 0);
    tag = "R12 mode1 gate low counts"; run(5, 1);
    tag = "R13 mode1 retrigger"; gateIn = 1; run(12, 0);

    tag = "R7 mode2"; load(5, 2); run(20, 0);
    tag = "R12 mode2 pause"; gateIn = 0; run(3, 0);
    tag = "R13 mode2 retrigger"; gateIn = 1; run(8, 0);
    tag = "R7 mode2 span1"; load(1, 2); run(5, 0);

    tag = "R8 mode3 odd"; load(7, 3); run(30, 0);
    tag = "R8 mode3 even"; load(8, 3); run(30, 1);
    tag = "R8 mode3 span3"; load(3, 3); run(12, 0);
    tag = "R13 mode3 retrigger"; gateIn = 0; run(2, 0); gateIn = 1; run(10, 0);

    tag = "R9 mode4"; load(4, 4); run(8, 0);
    gateIn = 0; run(2, 0); gateIn = 1; run(3, 0);
    tag = "R9 mode5"; load(4, 5); run(8, 0);
    tag = "R13 mode5 retrigger"; gateIn = 0; run(2, 0); gateIn = 1; run(8, 0);

    tag = "R11 mode6"; load(5, 6); run(14, 0);
    tag = "R11 mode7"; load(6, 7); run(14, 0);

    // R14: load together with tick and gate rise
    tag = "R14 load priority";
    load(9, 2); run(3, 0); gateIn = 0; run(1, 0);
    gateIn = 1; tickEn = 1; load(12, 1); tickEn = 0; run(4, 0);
    tag = "R14 no tick holds"; run(5, 2);

    tag = "R10 mode0 full span"; load(0, 0); run(65540, 0);
    tag = "R10 mode3 full span"; load(0, 3); run(40, 0);
    tag = "R10 mode2 full span"; load(0, 2); run(20, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20ns * 190000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule